// File: doc/BRIEF.md
# Sum-of-Products Output Cell

This block is a single output cell of a sum-of-products logic array. The array in front of it has already evaluated its product terms. The cell ORs a parameterised group of those terms into one sum. It then sends that sum to the output pin, either straight through or through a D flip-flop, with either polarity. One more product term drives the output enable on its own. Two further product terms reach the flip-flop: one clears it asynchronously and one sets it at the next clock edge.

A test preload path can force the flip-flop to a chosen level at a clock edge. A lock input shuts that path off. The cell also returns a feedback bit to the array. All configuration arrives as static inputs. A full array places ten of these cells side by side, each with its own term count between 8 and 16.

Top module: `sop_out_cell`

## Requirements
- R1: The sum is the OR of all `NUM_PT` bits of `pt_i`. In a combinatorial mode, `pin_o` follows the sum in the same cycle, for any single set term from bit 0 up to the top bit, and is low-true when no term is set.
- R2: `mode_i[1]` selects registered (1) or combinatorial (0). `mode_i[0]` selects active-low (1, so `pin_o` is the inverse of the selected data) or active-high (0).
- R3: A clock edge with `rst_ni` low clears the flip-flop to 0. `pin_o` then shows 0 in a registered active-high mode and 1 in a registered active-low mode.
- R4: While `ar_pt_i` is high, the flip-flop is 0 at once, with no clock edge needed.
- R5: With `sp_pt_i` high and no preload and no clear, the flip-flop becomes 1 at the next rising edge, whatever the sum is.
- R6: When `ar_pt_i` and `sp_pt_i` are both high, the flip-flop stays 0.
- R7: `pin_oe_o` is high exactly when `pt_oe_i` is high, in every mode.
- R8: With `preload_en_i` high and `lock_i` low, the next edge loads `preload_val_i` into the flip-flop. This load overrides both the sum and `sp_pt_i`.
- R9: When `lock_i` is high, `preload_en_i` has no effect: the edge performs the normal capture.
- R10: A preload request never overrides `ar_pt_i`; the flip-flop stays 0.
- R11: `fb_o` is the flip-flop's true output in a registered mode and equals `pin_o` in a combinatorial mode.
- R12: In a registered mode with no preset, preload or clear, each rising edge captures the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset (power-up clear) |
| pt_i | input | NUM_PT | Product terms feeding the OR sum |
| pt_oe_i | input | 1 | Output-enable product term |
| ar_pt_i | input | 1 | Asynchronous clear product term |
| sp_pt_i | input | 1 | Synchronous set product term |
| mode_i | input | 2 | Bit 1 registered, bit 0 active-low |
| preload_en_i | input | 1 | Test preload request |
| preload_val_i | input | 1 | Level to preload |
| lock_i | input | 1 | Blocks the preload path when high |
| pin_o | output | 1 | Pin data |
| pin_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
The bench targets the priority ladder among clear, preload, preset and capture. It drives each pair of these at once. A design that ranks preload above the clear, or the preset above the clear, would leave a 1 in the flip-flop. It also raises the clear in mid-cycle and samples before any edge, which catches a clear that waits for the clock. It drives the lowest and highest term bits on their own, which exposes an OR that misses an end of the vector. Finally, it reads feedback with active-low registered output, where a cell that feeds back the pin instead of the flip-flop shows the inverted value.

// File: rtl/sop_cell_pkg.sv
// Package: shared mode encoding for the sum-of-products output cell.
// Assumes the mode word is two static bits.
package sop_cell_pkg;
    localparam int MODE_W       = 2;
    localparam int MODE_REG_BIT = 1;   // 1 = registered path
    localparam int MODE_INV_BIT = 0;   // 1 = active-low pin

    typedef enum logic [MODE_W-1:0] {
        MODE_COMB_HI = 2'b00,
        MODE_COMB_LO = 2'b01,
        MODE_REG_HI  = 2'b10,
        MODE_REG_LO  = 2'b11
    } cell_mode_e;
endpackage

// File: rtl/sop_term_or.sv
// Module: ORs NUM_PT product terms into one sum through a ripple chain.
// Assumes the terms are already evaluated and stable before the clock edge.
module sop_term_or #(
    parameter int NUM_PT = 12
) (
    input  logic [NUM_PT-1:0] pt_i,
    output logic              sum_o
);
    logic [NUM_PT-1:0] chain;

    assign chain[0] = pt_i[0];
    for (genvar i = 1; i < NUM_PT; i++) begin : g_or
        assign chain[i] = chain[i-1] | pt_i[i];
    end
    assign sum_o = chain[NUM_PT-1];
endmodule

// File: rtl/sop_cell_ff.sv
// Module: the cell's D flip-flop with its control ladder.
// Priority, highest first: async clear term, sync reset, unlocked preload,
// sync preset, capture of the data input.
// Assumes ar_i is glitch-free, since it acts without the clock.
module sop_cell_ff (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ar_i,
    input  logic sp_i,
    input  logic pl_en_i,
    input  logic pl_val_i,
    input  logic lock_i,
    input  logic d_i,
    output logic q_o
);
    logic pl_go;

    // Purpose: a preload counts only when the lock is off.
    assign pl_go = pl_en_i & ~lock_i;

    // Purpose: hold state, clear at once on ar_i, otherwise update by priority.
    always_ff @(posedge clk_i or posedge ar_i) begin
        if (ar_i)         q_o <= 1'b0;
        else if (!rst_ni) q_o <= 1'b0;
        else if (pl_go)   q_o <= pl_val_i;
        else if (sp_i)    q_o <= 1'b1;
        else              q_o <= d_i;
    end
endmodule

// File: rtl/sop_cell_drive.sv
// Module: picks the registered or combinatorial value, applies the
// polarity, and forms the feedback bit.
// Assumes the mode bits are static.
module sop_cell_drive
    import sop_cell_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              sum_i,
    input  logic              q_i,
    output logic              pin_o,
    output logic              fb_o
);
    logic sel;

    // Purpose: choose the data source, then the polarity, then the feedback source.
    always_comb begin
        sel   = mode_i[MODE_REG_BIT] ? q_i : sum_i;
        pin_o = mode_i[MODE_INV_BIT] ? ~sel : sel;
        fb_o  = mode_i[MODE_REG_BIT] ? q_i : pin_o;
    end
endmodule

// File: rtl/sop_out_cell.sv
// Module: top of one sum-of-products output cell.
// Assumes the product terms, the enable term and the mode come from an
// array outside this block, and that the tri-state buffer sits outside it too.
module sop_out_cell
    import sop_cell_pkg::*;
#(
    parameter int NUM_PT = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_PT-1:0] pt_i,
    input  logic              pt_oe_i,
    input  logic              ar_pt_i,
    input  logic              sp_pt_i,
    input  logic [1:0]        mode_i,
    input  logic              preload_en_i,
    input  logic              preload_val_i,
    input  logic              lock_i,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic              fb_o
);
    logic sum;
    logic ff_q;

    sop_term_or #(.NUM_PT(NUM_PT)) u_or (
        .pt_i  (pt_i),
        .sum_o (sum)
    );

    sop_cell_ff u_ff (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ar_i     (ar_pt_i),
        .sp_i     (sp_pt_i),
        .pl_en_i  (preload_en_i),
        .pl_val_i (preload_val_i),
        .lock_i   (lock_i),
        .d_i      (sum),
        .q_o      (ff_q)
    );

    sop_cell_drive u_drv (
        .mode_i (mode_i),
        .sum_i  (sum),
        .q_i    (ff_q),
        .pin_o  (pin_o),
        .fb_o   (fb_o)
    );

    // Purpose: the enable term goes to the pin buffer unchanged.
    assign pin_oe_o = pt_oe_i;
endmodule

// File: rtl/sop_out_cell_chk.sv
// Module: checker bound to sop_out_cell. It relates the flip-flop state
// to the control terms across clock edges.
module sop_out_cell_chk #(
    parameter int NUM_PT = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_PT-1:0] pt_i,
    input logic              ar_pt_i,
    input logic              sp_pt_i,
    input logic [1:0]        mode_i,
    input logic              preload_en_i,
    input logic              preload_val_i,
    input logic              lock_i,
    input logic              pin_o,
    input logic              fb_o,
    input logic              ff_q
);
    p_reset_clear_r3: assert property (@(posedge clk_i)
        !rst_ni |=> !ff_q);

    p_async_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ar_pt_i |-> !ff_q);

    p_preset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sp_pt_i && !ar_pt_i && !(preload_en_i && !lock_i)) |=> (ff_q || ar_pt_i));

    p_clear_beats_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ar_pt_i && sp_pt_i) |-> !ff_q);

    p_preload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preload_en_i && !lock_i && !ar_pt_i) |=> ((ff_q == $past(preload_val_i)) || ar_pt_i));

    p_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preload_en_i && lock_i && !sp_pt_i && !ar_pt_i) |=> ((ff_q == $past(|pt_i)) || ar_pt_i));

    p_fb_reg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i[1] |-> (fb_o == ff_q));

    p_fb_comb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i[1] |-> (fb_o == pin_o));

    p_capture_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preload_en_i && !sp_pt_i && !ar_pt_i) |=> ((ff_q == $past(|pt_i)) || ar_pt_i));
endmodule

bind sop_out_cell sop_out_cell_chk #(.NUM_PT(NUM_PT)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pt_i          (pt_i),
    .ar_pt_i       (ar_pt_i),
    .sp_pt_i       (sp_pt_i),
    .mode_i        (mode_i),
    .preload_en_i  (preload_en_i),
    .preload_val_i (preload_val_i),
    .lock_i        (lock_i),
    .pin_o         (pin_o),
    .fb_o          (fb_o),
    .ff_q          (ff_q)
);

// File: tb/sop_out_cell_bench.sv
// Bench: scoreboard. The driver task sets inputs after a falling edge,
// works out from the requirements what the outputs must be after the next
// rising edge, and queues that expectation. The monitor pops it shortly
// after the rising edge and compares.
module sop_out_cell_bench;
    localparam int  NPT    = 12;
    localparam time CLK_PD = 10;

    typedef struct {
        logic  pin;
        logic  oe;
        logic  fb;
        string req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NPT-1:0] pt;
    logic           oe_t, ar, sp, pl_en, pl_val, lock;
    logic [1:0]     mode;
    logic           pin, pin_oe, fb;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_err  = 0;
    logic q_m    = 1'b0;
    bit   done   = 1'b0;

    sop_out_cell #(.NUM_PT(NPT)) u_sop_out_cell (
        .clk_i(clk), .rst_ni(rst_n), .pt_i(pt), .pt_oe_i(oe_t),
        .ar_pt_i(ar), .sp_pt_i(sp), .mode_i(mode),
        .preload_en_i(pl_en), .preload_val_i(pl_val), .lock_i(lock),
        .pin_o(pin), .pin_oe_o(pin_oe), .fb_o(fb)
    );

    always #(CLK_PD/2) clk = ~clk;

    task automatic check1(input string req, input logic act, input logic expv, input string what);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
        end
    endtask

    // Driver: one clock cycle of stimulus plus the expected outputs after the edge.
    task automatic drive(input logic [NPT-1:0] p, input logic o, input logic a,
                         input logic s, input logic pe, input logic pv,
                         input logic lk, input logic [1:0] md, input logic r,
                         input string req);
        exp_t e;
        logic sum, sel;
        @(negedge clk);
        pt = p; oe_t = o; ar = a; sp = s; pl_en = pe; pl_val = pv;
        lock = lk; mode = md; rst_n = r;
        sum = |p;
        if (a)             q_m = 1'b0;
        else if (!r)       q_m = 1'b0;
        else if (pe && !lk) q_m = pv;
        else if (s)        q_m = 1'b1;
        else               q_m = sum;
        sel   = md[1] ? q_m : sum;
        e.pin = md[0] ? ~sel : sel;
        e.oe  = o;
        e.fb  = md[1] ? q_m : e.pin;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare a queued expectation shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check1(e.req, pin, e.pin, "pin");
                check1(e.req, pin_oe, e.oe, "oe");
                check1(e.req, fb, e.fb, "fb");
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PD * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    localparam logic [1:0] C_HI = 2'b00, C_LO = 2'b01, R_HI = 2'b10, R_LO = 2'b11;
    localparam logic [NPT-1:0] Z = '0;

    initial begin
        rst_n = 1'b0; pt = '0; oe_t = 1'b0; ar = 1'b0; sp = 1'b0;
        pl_en = 1'b0; pl_val = 1'b0; lock = 1'b0; mode = R_HI;
        // R3: reset clears the flop; the pin level follows polarity
        drive(Z, 0, 0, 0, 0, 0, 0, R_HI, 0, "R3");
        drive({NPT{1'b1}}, 0, 0, 0, 0, 0, 0, R_LO, 0, "R3");
        // R1 R2 R7 R11: combinatorial modes with single terms at both ends
        drive(Z | 1, 1, 0, 0, 0, 0, 0, C_HI, 1, "R1");
        drive(Z | (1 << (NPT-1)), 1, 0, 0, 0, 0, 0, C_HI, 1, "R1");
        drive(Z, 0, 0, 0, 0, 0, 0, C_HI, 1, "R1");
        drive(Z, 1, 0, 0, 0, 0, 0, C_LO, 1, "R2");
        drive(Z | 4, 0, 0, 0, 0, 0, 0, C_LO, 1, "R11");
        drive(Z | 8, 1, 0, 0, 0, 0, 0, C_HI, 1, "R7");
        // R12: registered capture of the sum
        drive(Z | 16, 1, 0, 0, 0, 0, 0, R_HI, 1, "R12");
        drive(Z, 1, 0, 0, 0, 0, 0, R_HI, 1, "R12");
        // R5: preset sets the flop though the sum is 0
        drive(Z, 1, 0, 1, 0, 0, 0, R_HI, 1, "R5");
        // R6: clear beats preset
        drive(Z, 1, 1, 1, 0, 0, 0, R_HI, 1, "R6");
        // R8: preload 0 overrides sum and preset, then preload 1 over a zero sum
        drive(Z | 32, 1, 0, 0, 0, 0, 0, R_HI, 1, "R12");
        drive(Z | 32, 1, 0, 1, 1, 0, 0, R_HI, 1, "R8");
        drive(Z, 1, 0, 0, 1, 1, 0, R_HI, 1, "R8");
        // R9: locked preload does nothing, capture happens
        drive(Z, 1, 0, 0, 1, 1, 1, R_HI, 1, "R9");
        drive(Z | 64, 1, 0, 0, 1, 0, 1, R_HI, 1, "R9");
        // R10: clear beats preload
        drive(Z, 1, 1, 0, 1, 1, 0, R_HI, 1, "R10");
        // R11 R2: active-low registered; feedback is the true flop value
        drive(Z | 1, 1, 0, 0, 0, 0, 0, R_LO, 1, "R11");
        // R4: clear in mid-cycle, sampled before any rising edge
        @(negedge clk);
        #1;
        check1("R4", fb, 1'b1, "fb before clear");
        ar = 1'b1;
        #1;
        check1("R4", fb, 1'b0, "fb after async clear");
        check1("R4", pin, 1'b1, "pin after async clear");
        q_m = 1'b0;
        drive(Z | 1, 1, 0, 0, 0, 0, 0, R_HI, 1, "R12");
        @(posedge clk);
        #(CLK_PD/2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule